// File: doc/BRIEF.md
# Radix-4 Delay-Commutator Butterfly Stage

This block is one stage of a single-path pipelined radix-4 decimation-in-frequency FFT. Its input is a single word stream in which every complex sample occupies two consecutive valid words: the real part, then the imaginary part. A commutator delay line holds the first half of each block, which is `D = N >> STAGE` samples (`2*D` words). The second half then meets its partners, which lie exactly `D` samples earlier.

One real adder and one real subtracter are shared in time between the real and imaginary words of each pair. On every second-half word the stage forms `a + b`, which it sends to the main output toward the next stage, and `a - b`, which it sends to the port feeding the twiddle multiplier. Both results are one bit wider than the input. They leave one register after the second-half word enters, with the same real/imaginary alternation the next stage expects. `valid_i` may drop at any time; the stage then freezes.

Top module: `fft_sdc_stage`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `sum_o`, `dif_o` and `im_o` are 0.
- R2: Valid words are numbered from reset in blocks of `4*D` words. The first `2*D` words of each block produce no result: in the cycle after each one, `valid_o` is 0 and all result outputs keep their values.
- R3: For word `j` (0 to `2*D-1`) of a block's second half, with `a` equal to word `j` of the same block's first half and `b` equal to the arriving word, `sum_o` equals `a + b` as a signed `W+1`-bit value one cycle later, and `valid_o` is 1.
- R4: In that same cycle, `dif_o` equals `a - b` as a signed `W+1`-bit value.
- R5: `im_o` on a result is 1 when its word position within the stream is odd (imaginary part) and 0 when it is even (real part), so results alternate real and imaginary.
- R6: A cycle with `valid_i` low advances neither the word count nor the delay line. In the following cycle, `valid_o` is 0 and `sum_o`, `dif_o` and `im_o` hold.
- R7: Full-scale operands never wrap: for example, `-2^(W-1) - (2^(W-1)-1)` appears exactly on `dif_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input word strobe |
| data_i | input | W | Signed input word (real, then imaginary) |
| valid_o | output | 1 | Result strobe |
| im_o | output | 1 | Result is an imaginary part |
| sum_o | output | W+1 | Butterfly sum, to next stage |
| dif_o | output | W+1 | Butterfly difference, to twiddle multiplier |

## Verification
A slipped word counter shifts the half-block boundary. That shows at the ports as results appearing for first-half words, or missing for second-half words, within one block of `4*D` words. It also inverts `im_o` on the first result. A delay line of the wrong length pairs a second-half word with the wrong partner. Both `sum_o` and `dif_o` then go wrong from the very first result of the second half, which is why the bench uses distinct operand patterns. A gap that leaks into the state shows up as a shifted pairing in the next result after the gap.

// File: rtl/fft_sdc_pkg.sv
package fft_sdc_pkg;
  function automatic int unsigned half_words(input int unsigned n, input int unsigned stage);
    return 2 * (n >> stage);
  endfunction
endpackage

// File: rtl/fft_sdc_ctrl.sv
module fft_sdc_ctrl #(
  parameter int unsigned N     = 16,
  parameter int unsigned STAGE = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic phase_b_o,
  output logic odd_o
);
  localparam int unsigned DW  = fft_sdc_pkg::half_words(N, STAGE);
  localparam int unsigned CW  = $clog2(2 * N);
  localparam int unsigned PHB = $clog2(DW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign phase_b_o = cnt_q[PHB];
  assign odd_o     = cnt_q[0];

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q)); // R6
  AST_PAR_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> odd_o != $past(odd_o)); // R5
endmodule

// File: rtl/fft_sdc_delay.sv
module fft_sdc_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] tap_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   tap_q[i] <= '0;
      else if (en_i) tap_q[i] <= (i == 0) ? d_i : tap_q[(i == 0) ? 0 : i - 1];
    end
  end

  assign q_o = tap_q[DEPTH-1];
endmodule

// File: rtl/fft_sdc_addsub.sv
module fft_sdc_addsub #(
  parameter int unsigned W = 8
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W:0]   sum_o,
  output logic signed [W:0]   dif_o
);
  logic signed [W:0] a_x, b_x;
  assign a_x   = {a_i[W-1], a_i};
  assign b_x   = {b_i[W-1], b_i};
  assign sum_o = a_x + b_x;
  assign dif_o = a_x - b_x;
endmodule

// File: rtl/fft_sdc_stage.sv
module fft_sdc_stage #(
  parameter int unsigned N     = 16,
  parameter int unsigned STAGE = 1,
  parameter int unsigned W     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] data_i,
  output logic                valid_o,
  output logic                im_o,
  output logic signed [W:0]   sum_o,
  output logic signed [W:0]   dif_o
);
  localparam int unsigned DW = fft_sdc_pkg::half_words(N, STAGE);

  logic              phase_b, odd;
  logic [W-1:0]      head;
  logic signed [W:0] sum_c, dif_c;
  logic              fire;

  fft_sdc_ctrl #(.N(N), .STAGE(STAGE)) u_ctrl (
    .clk_i, .rst_ni, .adv_i(valid_i), .phase_b_o(phase_b), .odd_o(odd)
  );

  fft_sdc_delay #(.W(W), .DEPTH(DW)) u_dly (
    .clk_i, .rst_ni, .en_i(valid_i), .d_i(data_i), .q_o(head)
  );

  fft_sdc_addsub #(.W(W)) u_bfly (
    .a_i(signed'(head)), .b_i(data_i), .sum_o(sum_c), .dif_o(dif_c)
  );

  assign fire = valid_i && phase_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      im_o    <= 1'b0;
      sum_o   <= '0;
      dif_o   <= '0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        im_o  <= odd;
        sum_o <= sum_c;
        dif_o <= dif_c;
      end
    end
  end

  AST_GAP_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R6
  AST_GAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sum_o) && $stable(dif_o) && $stable(im_o)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($signed({sum_o[W], sum_o}) - $signed({dif_o[W], dif_o}))
                == ($signed({{2{$past(data_i[W-1])}}, $past(data_i)}) <<< 1)); // R7
  AST_PAIR_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i)); // R2
endmodule

// File: tb/fft_sdc_stage_tb.sv
module fft_sdc_stage_tb;
  localparam int unsigned N = 16, STAGE = 1, W = 8;
  localparam int unsigned DW = 2 * (N >> STAGE);
  localparam int unsigned BLK = 2 * DW;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic signed [W-1:0] data_i = '0;
  logic valid_o, im_o;
  logic signed [W:0] sum_o, dif_o;

  always #4 clk = ~clk;

  fft_sdc_stage #(.N(N), .STAGE(STAGE), .W(W)) u_dut (
    .clk_i(clk), .rst_ni, .valid_i, .data_i, .valid_o, .im_o, .sum_o, .dif_o
  );

  typedef struct packed {
    logic v; logic im; logic signed [W:0] s; logic signed [W:0] d; logic gap;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  int unsigned wc = 0;
  logic signed [W-1:0] ahalf [DW];
  logic m_im = 1'b0;
  logic signed [W:0] m_s = '0, m_d = '0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic signed [W-1:0] d);
    exp_t e;
    @(negedge clk); #1;
    valid_i = v; data_i = d;
    e.v = 1'b0; e.gap = !v;
    if (v) begin
      if (wc < DW) ahalf[wc] = d;
      else begin
        e.v  = 1'b1;
        m_im = wc[0];
        m_s  = $signed({ahalf[wc-DW][W-1], ahalf[wc-DW]}) + $signed({d[W-1], d});
        m_d  = $signed({ahalf[wc-DW][W-1], ahalf[wc-DW]}) - $signed({d[W-1], d});
      end
      wc = (wc + 1) % BLK;
    end
    e.im = m_im; e.s = m_s; e.d = m_d;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.gap) chk(valid_o == 1'b0, "R6 gap valid_o", valid_o, 0);
        else if (e.v) chk(valid_o == 1'b1, "R3 valid_o", valid_o, 1);
        else chk(valid_o == 1'b0, "R2 first-half valid_o", valid_o, 0);
        chk(sum_o == e.s, e.v ? "R3 sum_o" : "R2/R6 sum_o hold", sum_o, e.s);
        chk(dif_o == e.d, e.v ? "R4 dif_o" : "R2/R6 dif_o hold", dif_o, e.d);
        chk(im_o == e.im, "R5 im_o", im_o, e.im);
      end
    end
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid_o", valid_o, 0);
    chk(sum_o == 0, "R1 sum_o", sum_o, 0);
    chk(dif_o == 0, "R1 dif_o", dif_o, 0);
    chk(im_o == 1'b0, "R1 im_o", im_o, 0);
    rst_ni = 1'b1;
    // ramp: a = i, b = 3*i+1
    for (int i = 0; i < DW; i++) drive(1'b1, W'(i));
    for (int i = 0; i < DW; i++) drive(1'b1, W'(3 * i + 1));
    // R7 extremes
    for (int i = 0; i < DW; i++) drive(1'b1, (i % 3 == 0) ? -8'sd128 : 8'sd127);
    for (int i = 0; i < DW; i++) drive(1'b1, (i % 2 == 0) ? 8'sd127 : -8'sd128);
    // gaps inside both halves (R6)
    for (int i = 0; i < DW; i++) begin
      drive(1'b1, W'(5 * i - 20));
      if (i % 4 == 1) begin drive(1'b0, 8'sd99); drive(1'b0, -8'sd7); end
    end
    for (int i = 0; i < DW; i++) begin
      if (i % 3 == 0) drive(1'b0, 8'sd55);
      drive(1'b1, W'(40 - 7 * i));
    end
    // pseudo-random with random gaps
    for (int k = 0; k < 12 * BLK; k++) begin
      int unsigned r;
      r = $urandom;
      drive(r[0] | r[1], W'(r >> 8));
    end
    repeat (3) drive(1'b0, '0);
    @(negedge clk); @(negedge clk);
    chk(q.size() == 0, "R3 queue drained", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule